// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder

This block encodes one bit per clock into a systematic quasi-cyclic LDPC codeword. The codeword has 7154 information bits and 1022 parity bits. The generator matrix has an identity part and two columns of 511 x 511 generator circulants, with 14 circulants in each column. Each information bit is passed straight to the output and is also used to update two parity accumulators, one for each circulant column. A set information bit XORs the current row of that column's generator circulant into the accumulator. The current row comes from a rotating register that holds the circulant's first row at the start of each 511-bit segment and rotates by one column for every bit.

After the last information bit the two accumulators are shifted out, the first column followed by the second, with no idle cycle in between. During that drain the input is held off. A frame-start flag sent with an information bit clears both accumulators and restarts the encoder at segment 0, even when a frame is part-way through. The circulant size, the segment count and the table of generator first rows are parameters, so a small code can be used for test.

Top module: `qcldpc_enc`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Each accepted information bit (`in_valid` and `in_ready` both high at a clock edge) appears on `out_bit` one cycle later, with `out_valid` = 1 and `out_is_parity` = 0, in the order the bits were accepted.
- R3: Parity bit m of column c (m = 0 .. CIRC-1, c = 0 or 1) is the XOR over every information bit i of u[i] AND F(s,c)[(m - i mod CIRC) mod CIRC], where s = i / CIRC. F(s,c)[k] is column k of the first row of the generator circulant. It is stored in table entry `GEN_TBL[(2*s + c)*512 +: 512]` at bit CIRC-1-k, so the leftmost column sits in the most significant used bit. Bit 511 (the pad) and all bits above CIRC-1 in an entry have no effect.
- R4: A frame holds exactly SEGS*CIRC information bits. Segment s uses the table entries for segment s, including the last segment, which is full.
- R5: In the cycle after the last information bit is output, the 2*CIRC parity bits begin on `out_bit` with `out_valid` = 1 and `out_is_parity` = 1 on consecutive cycles. Column 0 comes first, from m = 0 upward, then column 1.
- R6: `in_ready` is 0 for exactly the 2*CIRC cycles of parity output and 1 at all other times. Input presented while `in_ready` is 0, including `in_sof`, is ignored.
- R7: An accepted bit with `in_sof` = 1 becomes information bit 0 of a new frame. The parity of the interrupted frame is discarded, even if that bit is also the first bit of a segment.
- R8: Cycles without an accepted bit outside the parity drain produce `out_valid` = 0 and do not change the codeword. After a drain the next accepted bit starts a new frame even without `in_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Information bit offered |
| in_bit | input | 1 | Information bit value |
| in_sof | input | 1 | Offered bit is the first of a new frame |
| in_ready | output | 1 | Encoder accepts an information bit this cycle |
| out_valid | output | 1 | `out_bit` carries a codeword bit |
| out_bit | output | 1 | Codeword bit, systematic part then parity |
| out_is_parity | output | 1 | Current output bit is a parity bit |

## Verification
A frame restart and a segment-row reload can happen in the same cycle. The bench provokes this by raising `in_sof` on the bit that would begin the second segment, so one clock edge has to both clear the accumulators and choose segment 0's row instead of segment 1's. It also raises `in_sof` at a mid-segment position, where no reload would otherwise occur. The bench keeps `in_valid` high with random bits and random `in_sof` throughout the parity drain, so that the hold-off meets a frame-start request. A behavioural model computes each codeword by matrix products over a stored copy of the frame and judges every output bit, the parity flag and `in_ready` on every clock.

// File: rtl/qcldpc_pkg.sv
package qcldpc_pkg;

   // Every generator first row occupies a 512-bit slot in the table.
   localparam int ROW_W     = 512;
   localparam int MAX_SEGS  = 16;
   localparam int NCOL      = 2;
   localparam int TBL_MAX_W = MAX_SEGS * NCOL * ROW_W;

   typedef enum logic {ST_INFO = 1'b0, ST_PAR = 1'b1} enc_state_t;

   // Placeholder table: a deterministic pseudo-random fill with the pad
   // bit cleared. An integrator overrides it with the real generator rows.
   function automatic logic [TBL_MAX_W-1:0] default_tbl();
      logic [31:0]          x = 32'h1F2E_3D4C;
      logic [TBL_MAX_W-1:0] t = '0;
      for (int w = 0; w < TBL_MAX_W / 32; w++) begin
         x = x ^ (x << 13);
         x = x ^ (x >> 17);
         x = x ^ (x << 5);
         t[w*32 +: 32] = x;
      end
      for (int e = 0; e < TBL_MAX_W / ROW_W; e++)
         t[e*ROW_W + ROW_W - 1] = 1'b0;
      return t;
   endfunction

endpackage

// File: rtl/qcldpc_seq.sv
module qcldpc_seq #(
   parameter int CIRC = 511,
   parameter int SEGS = 14,
   localparam int POS_W = $clog2(CIRC),
   localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1,
   localparam int PC_W  = $clog2(2 * CIRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             sof,
   output logic             ready,
   output logic             load_row,
   output logic [SEG_W-1:0] seg_sel,
   output logic             clr,
   output logic             shift0,
   output logic             shift1,
   output logic             par_busy
);
   import qcldpc_pkg::*;

   enc_state_t       state_q;
   logic [POS_W-1:0] pos_q;
   logic [SEG_W-1:0] seg_q;
   logic [PC_W-1:0]  pcnt_q;

   logic [POS_W-1:0] cur_pos;
   logic [SEG_W-1:0] cur_seg;
   logic             seg_last, frame_last;

   always_comb begin
      cur_pos    = sof ? '0 : pos_q;
      cur_seg    = sof ? '0 : seg_q;
      seg_last   = (cur_pos == POS_W'(CIRC - 1));
      frame_last = seg_last && (cur_seg == SEG_W'(SEGS - 1));
   end

   assign ready    = (state_q == ST_INFO);
   assign par_busy = (state_q == ST_PAR);
   assign load_row = take && (cur_pos == '0);
   assign seg_sel  = cur_seg;
   assign clr      = take && sof;
   assign shift0   = par_busy && (pcnt_q <  PC_W'(CIRC));
   assign shift1   = par_busy && (pcnt_q >= PC_W'(CIRC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INFO;
         pos_q   <= '0;
         seg_q   <= '0;
         pcnt_q  <= '0;
      end else if (state_q == ST_INFO) begin
         if (take) begin
            if (frame_last) begin
               pos_q   <= '0;
               seg_q   <= '0;
               pcnt_q  <= '0;
               state_q <= ST_PAR;
            end else if (seg_last) begin
               pos_q <= '0;
               seg_q <= cur_seg + 1'b1;
            end else begin
               pos_q <= cur_pos + 1'b1;
               seg_q <= cur_seg;
            end
         end
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
         if (pcnt_q == PC_W'(2 * CIRC - 1))
            state_q <= ST_INFO;
      end
   end

   // R6: nothing is accepted while parity drains
   a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      par_busy |-> !take);
   // R5: drain lasts exactly 2*CIRC cycles, then input reopens
   a_r5_drain_end: assert property (@(posedge clk) disable iff (!rst_n)
      (par_busy && pcnt_q == PC_W'(2 * CIRC - 1)) |=> ready);

endmodule

// File: rtl/qcldpc_col.sv
module qcldpc_col #(
   parameter int CIRC = 511,
   parameter int SEGS = 14,
   parameter int COL  = 0,
   parameter logic [qcldpc_pkg::TBL_MAX_W-1:0] GEN_TBL = qcldpc_pkg::default_tbl(),
   localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             in_bit,
   input  logic             load_row,
   input  logic [SEG_W-1:0] seg_sel,
   input  logic             clr,
   input  logic             shift,
   output logic             lsb,
   output logic             acc_zero
);
   import qcldpc_pkg::*;

   logic [CIRC-1:0]  gen_q, acc_q;
   logic [CIRC-1:0]  first_row, cur_row;
   logic [ROW_W-1:0] entry;
   int               base;

   // Column k of the first row is entry bit CIRC-1-k; the pad is unused.
   always_comb begin
      base  = (int'(seg_sel) * NCOL + COL) * ROW_W;
      entry = GEN_TBL[base +: ROW_W];
      for (int m = 0; m < CIRC; m++)
         first_row[m] = entry[CIRC-1-m];
      cur_row = load_row ? first_row : gen_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= '0;
         acc_q <= '0;
      end else if (take) begin
         gen_q <= {cur_row[CIRC-2:0], cur_row[CIRC-1]};
         acc_q <= (clr ? '0 : acc_q) ^ (in_bit ? cur_row : '0);
      end else if (shift) begin
         acc_q <= acc_q >> 1;
      end
   end

   assign lsb      = acc_q[0];
   assign acc_zero = (acc_q == '0);

   // R3: a rotation keeps the weight of the generator row
   a_r3_rot_weight: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(take) && !$past(load_row)) |->
         ($countones(gen_q) == $countones($past(gen_q))));

endmodule

// File: rtl/qcldpc_enc.sv
module qcldpc_enc #(
   parameter int CIRC = 511,
   parameter int SEGS = 14,
   parameter logic [qcldpc_pkg::TBL_MAX_W-1:0] GEN_TBL = qcldpc_pkg::default_tbl()
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   input  logic in_sof,
   output logic in_ready,
   output logic out_valid,
   output logic out_bit,
   output logic out_is_parity
);
   import qcldpc_pkg::*;

   localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1;

   if (CIRC < 2 || CIRC > ROW_W) begin : g_bad_circ
      $error("qcldpc_enc: CIRC must lie in 2..%0d", ROW_W);
   end
   if (SEGS < 1 || SEGS > MAX_SEGS) begin : g_bad_segs
      $error("qcldpc_enc: SEGS must lie in 1..%0d", MAX_SEGS);
   end

   logic             take, load_row, clr, par_busy;
   logic [SEG_W-1:0] seg_sel;
   logic [NCOL-1:0]  shift_v, lsb_v, zero_v;

   assign take = in_valid && in_ready;

   qcldpc_seq #(.CIRC(CIRC), .SEGS(SEGS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .sof     (in_sof),
      .ready   (in_ready),
      .load_row(load_row),
      .seg_sel (seg_sel),
      .clr     (clr),
      .shift0  (shift_v[0]),
      .shift1  (shift_v[1]),
      .par_busy(par_busy)
   );

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      qcldpc_col #(.CIRC(CIRC), .SEGS(SEGS), .COL(c), .GEN_TBL(GEN_TBL)) u_col (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (take),
         .in_bit  (in_bit),
         .load_row(load_row),
         .seg_sel (seg_sel),
         .clr     (clr),
         .shift   (shift_v[c]),
         .lsb     (lsb_v[c]),
         .acc_zero(zero_v[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_bit       <= 1'b0;
         out_is_parity <= 1'b0;
      end else begin
         out_valid     <= take || par_busy;
         out_is_parity <= par_busy;
         out_bit       <= take ? in_bit : (shift_v[1] ? lsb_v[1] : lsb_v[0]);
      end
   end

   // R2: systematic bit follows one cycle after acceptance
   a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_valid && !out_is_parity && out_bit == $past(in_bit)));
   // R5: parity flag only on valid output
   a_r5_flag_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_parity |-> out_valid);
   // R8: a finished drain leaves both accumulators empty
   a_r8_drained: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(par_busy) |-> (&zero_v));

endmodule

// File: tb/qcldpc_enc_tb_top.sv
module qcldpc_enc_tb_top;
   localparam int CIRC  = 31;
   localparam int SEGS  = 4;
   localparam int K     = CIRC * SEGS;
   localparam int TW    = qcldpc_pkg::TBL_MAX_W;

   function automatic logic [TW-1:0] bench_tbl();
      logic [31:0]   x = 32'hC0DE_1234;
      logic [TW-1:0] t = '0;
      for (int w = 0; w < TW / 32; w++) begin
         x = x ^ (x << 7);
         x = x ^ (x >> 9);
         x = x ^ (x << 8);
         t[w*32 +: 32] = x;   // pad and unused bits stay random (R3)
      end
      return t;
   endfunction

   localparam logic [TW-1:0] TBL = bench_tbl();

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0;
   logic in_ready, out_valid, out_bit, out_is_parity;

   always #5 clk = ~clk;

   qcldpc_enc #(.CIRC(CIRC), .SEGS(SEGS), .GEN_TBL(TBL)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
      .in_sof(in_sof), .in_ready(in_ready), .out_valid(out_valid),
      .out_bit(out_bit), .out_is_parity(out_is_parity)
   );

   int    n_chk = 0, n_fail = 0;
   string ptag = "R3";
   bit    done = 0;

   task automatic chk(string tag, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit info [K];
   bit par  [2*CIRC];
   int cnt = 0, pidx = -1;
   bit exp_v = 0, exp_b = 0, exp_p = 0;

   function automatic void compute_parity();
      for (int c = 0; c < 2; c++)
         for (int m = 0; m < CIRC; m++) begin
            bit p = 0;
            for (int i = 0; i < K; i++) begin
               int s = i / CIRC;
               int k = ((m - (i % CIRC)) % CIRC + CIRC) % CIRC;
               p ^= info[i] & TBL[(2*s + c)*512 + CIRC - 1 - k];
            end
            par[c*CIRC + m] = p;
         end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         cnt = 0; pidx = -1; exp_v = 0; exp_b = 0; exp_p = 0;
      end else if (pidx < 0 && in_valid) begin
         if (in_sof) cnt = 0;
         info[cnt] = in_bit;
         cnt++;
         exp_v = 1; exp_b = in_bit; exp_p = 0;
         if (cnt == K) begin
            compute_parity();
            cnt = 0;
            pidx = 0;
         end
      end else if (pidx >= 0) begin
         exp_v = 1; exp_b = par[pidx]; exp_p = 1;
         pidx++;
         if (pidx == 2*CIRC) pidx = -1;
      end else begin
         exp_v = 0; exp_p = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6", in_ready, pidx < 0, "in_ready");
         chk(exp_v ? (exp_p ? "R5" : "R2") : "R8", out_valid, exp_v, "out_valid");
         if (exp_v) begin
            chk("R5", out_is_parity, exp_p, "out_is_parity");
            chk(exp_p ? ptag : "R2", out_bit, exp_b, "out_bit");
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(bit b, bit s);
      forever begin
         @(negedge clk);
         if (in_ready) begin
            in_valid = 1; in_bit = b; in_sof = s;
            break;
         end
         // offered while held off: must be ignored (R6)
         in_valid = 1; in_bit = 1'($urandom); in_sof = 1'($urandom);
      end
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 0; in_sof = 0;
      end
   endtask

   // kind: 0 zeros, 1 ones, 2 random, 3 single one at index hot
   task automatic frame(int kind, bit sof, int hot, bit gaps, int nbits);
      for (int i = 0; i < nbits; i++) begin
         bit b = (kind == 1) || (kind == 2 && 1'($urandom)) || (kind == 3 && i == hot);
         send(b, sof && i == 0);
         if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1", in_ready, 1'b1, "reset in_ready");
      chk("R1", out_valid, 1'b0, "reset out_valid");

      ptag = "R3"; frame(0, 0, 0, 0, K);       // auto start, all zeros
      ptag = "R3"; frame(1, 1, 0, 0, K);       // all ones, back to back
      ptag = "R4"; frame(3, 1, K - 1, 0, K);   // last bit of last segment
      ptag = "R4"; frame(3, 1, 2 * CIRC, 0, K);// first bit of segment 2
      ptag = "R8"; frame(2, 0, 0, 1, K);       // random with gaps
      idle(2 * CIRC + 4);
      ptag = "R7"; frame(2, 1, 0, 0, CIRC);    // stop at segment boundary
      frame(2, 1, 0, 0, K);                    // restart coincides with reload
      ptag = "R7"; frame(2, 1, 0, 1, 10);      // mid-segment interruption
      frame(2, 1, 0, 1, K);
      ptag = "R3"; frame(2, 1, 0, 0, K);
      idle(2 * CIRC + 6);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule